// File: doc/BRIEF.md
# Soft-Switch Memory Bank Decoder

This block routes every access of an 8-bit CPU with a 16-bit address space to one of five targets: main RAM, auxiliary RAM, ROM, the on-board I/O page, or nothing at all. Its inputs are the CPU address, a write strobe and eleven mode flags. The flags are held elsewhere as soft switches. They cover these functions:

- alternate zero page/stack
- auxiliary select, with one flag for reads and one for writes
- 80-column store
- display page 2
- text mode
- internal slot ROM
- slot-3 card ownership
- upper-area RAM read enable
- upper-area write inhibit
- upper-area 4 KB bank choice

The block classifies the address into one of its segments and applies that segment's rule. The result is registered. Alongside the target select it gives a RAM address. For one of the two 4 KB banks behind 0xD000–0xDFFF, that address is folded down to 0xC000–0xCFFF, so both banks have distinct RAM locations.

A memory controller places the decoder between the CPU bus and the RAM, ROM and I/O enables. The target select reaches the memory side one clock after the address and flags are presented.

Top module: `bank_decoder`

## Requirements
- R1: `tgt_sel` is one-hot with bit 0 = main RAM, bit 1 = aux RAM, bit 2 = ROM, bit 3 = I/O, bit 4 = unmapped. Outputs register the decode of the inputs sampled at the previous rising clock edge. While `rst` is high, the next edge sets `tgt_sel` to 5'b10000 and `ram_addr` to 0.
- R2: For 0x0000–0x01FF, reads and writes go to aux RAM when `alt_zp` is 1, and to main RAM otherwise.
- R3: For 0x0200–0x03FF, 0x0800–0x0FFF and 0x2000–0xBFFF, a read goes to aux when `aux_rd` is 1 and a write goes to aux when `aux_wr` is 1. Otherwise the access goes to main.
- R4: For 0x0400–0x07FF with `store80` = 1, the access goes to aux when `page2` = 1 and to main otherwise. With `store80` = 0, the rule of R3 applies.
- R5: For 0x1000–0x1FFF the rule of R4 applies, except that the `page2` path selects aux only when `text_mode` = 0.
- R6: 0xC000–0xC0FF selects I/O for any flags and either direction.
- R7: 0xC100–0xC2FF and 0xC400–0xCFFF select ROM when `slot_rom_int` = 1 and unmapped otherwise.
- R8: 0xC300–0xC3FF selects ROM when `slot_rom_int` = 1 or `slot3_card` = 0, and unmapped otherwise.
- R9: A read in 0xD000–0xFFFF selects ROM when `lc_ram_rd` = 0. Otherwise it goes to aux if `alt_zp` = 1 and to main if not.
- R10: A write in 0xD000–0xFFFF is unmapped when `lc_wr_inh` = 1. Otherwise it goes to aux if `alt_zp` = 1 and to main if not.
- R11: `ram_addr` equals the address, except in 0xD000–0xDFFF with `lc_bank2` = 0, where bit 12 is cleared (mapped to 0xC000–0xCFFF). Addresses 0xE000–0xFFFF ignore `lc_bank2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | CPU address |
| wr | input | 1 | 1 = write access, 0 = read |
| alt_zp | input | 1 | Alternate zero page/stack and upper-area RAM to aux |
| aux_rd | input | 1 | Reads of general RAM go to aux |
| aux_wr | input | 1 | Writes of general RAM go to aux |
| store80 | input | 1 | Display pages follow page2 instead of aux_rd/aux_wr |
| page2 | input | 1 | Second display page selected |
| text_mode | input | 1 | Text display mode |
| slot_rom_int | input | 1 | Internal ROM covers the slot area |
| slot3_card | input | 1 | Card in slot 3 owns its ROM page |
| lc_ram_rd | input | 1 | Upper area reads RAM instead of ROM |
| lc_wr_inh | input | 1 | Upper area writes are discarded |
| lc_bank2 | input | 1 | 0xD000 window shows bank 2 (1) or bank 1 (0) |
| tgt_sel | output | 5 | One-hot target: main, aux, ROM, I/O, unmapped |
| ram_addr | output | 16 | RAM address with bank fold applied |

## Verification
The bench checks every segment boundary, the first and last address of each range, in both directions. Each access runs with all flags clear, then all set, then each flag toggled alone. This separates which flag each segment really listens to from flags that must have no effect there. In the display regions, the bench pairs `store80` with `page2` and `text_mode` against the opposite setting of `aux_rd`/`aux_wr`, so the override path and the plain aux path cannot mask each other. Seeded random addresses with random flags fill the space between the boundaries. The bench also sets `lc_bank2` both ways at 0xDFFF and 0xE000, which exposes a fold applied to the wrong range.

// File: rtl/bank_decoder_pkg.sv
package bank_decoder_pkg;
  localparam int TGT_N    = 5;
  localparam int TGT_MAIN = 0;
  localparam int TGT_AUX  = 1;
  localparam int TGT_ROM  = 2;
  localparam int TGT_IO   = 3;
  localparam int TGT_NONE = 4;

  typedef enum logic [3:0] {
    SEG_ZP, SEG_GEN, SEG_TXT, SEG_HIRES, SEG_IO,
    SEG_SLOT, SEG_C3, SEG_LCD, SEG_LCE
  } seg_e;

  typedef struct packed {
    logic alt_zp;
    logic aux_rd;
    logic aux_wr;
    logic store80;
    logic page2;
    logic text_mode;
    logic slot_rom_int;
    logic slot3_card;
    logic lc_ram_rd;
    logic lc_wr_inh;
  } mode_t;
endpackage

// File: rtl/bank_seg_classify.sv
module bank_seg_classify
  import bank_decoder_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output seg_e              seg
);
  localparam int PG_W = 8;
  logic [PG_W-1:0] pg;
  assign pg = addr[ADDR_W-1 -: PG_W];

  always_comb begin
    if (pg < 8'h02)       seg = SEG_ZP;
    else if (pg < 8'h04)  seg = SEG_GEN;
    else if (pg < 8'h08)  seg = SEG_TXT;
    else if (pg < 8'h10)  seg = SEG_GEN;
    else if (pg < 8'h20)  seg = SEG_HIRES;
    else if (pg < 8'hC0)  seg = SEG_GEN;
    else if (pg == 8'hC0) seg = SEG_IO;
    else if (pg == 8'hC3) seg = SEG_C3;
    else if (pg < 8'hD0)  seg = SEG_SLOT;
    else if (pg < 8'hE0)  seg = SEG_LCD;
    else                  seg = SEG_LCE;
  end
endmodule

// File: rtl/bank_target_route.sv
module bank_target_route
  import bank_decoder_pkg::*;
(
  input  seg_e             seg,
  input  logic             wr,
  input  mode_t            mode,
  output logic [TGT_N-1:0] tgt
);
  logic aux_dir;
  logic lc_ram;

  assign aux_dir = wr ? mode.aux_wr : mode.aux_rd;
  assign lc_ram  = wr ? !mode.lc_wr_inh : mode.lc_ram_rd;

  always_comb begin
    tgt = '0;
    unique case (seg)
      SEG_ZP:    tgt[mode.alt_zp ? TGT_AUX : TGT_MAIN] = 1'b1;
      SEG_GEN:   tgt[aux_dir ? TGT_AUX : TGT_MAIN] = 1'b1;
      SEG_TXT:
        if (mode.store80) tgt[mode.page2 ? TGT_AUX : TGT_MAIN] = 1'b1;
        else              tgt[aux_dir ? TGT_AUX : TGT_MAIN] = 1'b1;
      SEG_HIRES:
        if (mode.store80)
          tgt[(mode.page2 && !mode.text_mode) ? TGT_AUX : TGT_MAIN] = 1'b1;
        else
          tgt[aux_dir ? TGT_AUX : TGT_MAIN] = 1'b1;
      SEG_IO:    tgt[TGT_IO] = 1'b1;
      SEG_SLOT:  tgt[mode.slot_rom_int ? TGT_ROM : TGT_NONE] = 1'b1;
      SEG_C3:
        tgt[(mode.slot_rom_int || !mode.slot3_card) ? TGT_ROM : TGT_NONE] = 1'b1;
      SEG_LCD, SEG_LCE:
        if (lc_ram)  tgt[mode.alt_zp ? TGT_AUX : TGT_MAIN] = 1'b1;
        else if (wr) tgt[TGT_NONE] = 1'b1;
        else         tgt[TGT_ROM] = 1'b1;
      default:   tgt[TGT_NONE] = 1'b1;
    endcase
  end
endmodule

// File: rtl/bank_addr_fold.sv
module bank_addr_fold
  import bank_decoder_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  seg_e              seg,
  input  logic              bank2,
  output logic [ADDR_W-1:0] ram_addr
);
  localparam logic [ADDR_W-1:0] FOLD_MASK = ~(ADDR_W'(1) << BANK_LOG2);

  always_comb begin
    if (seg == SEG_LCD && !bank2) ram_addr = addr & FOLD_MASK;
    else                          ram_addr = addr;
  end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_decoder_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              alt_zp,
  input  logic              aux_rd,
  input  logic              aux_wr,
  input  logic              store80,
  input  logic              page2,
  input  logic              text_mode,
  input  logic              slot_rom_int,
  input  logic              slot3_card,
  input  logic              lc_ram_rd,
  input  logic              lc_wr_inh,
  input  logic              lc_bank2,
  output logic [TGT_N-1:0]  tgt_sel,
  output logic [ADDR_W-1:0] ram_addr
);
  seg_e              seg;
  mode_t             mode;
  logic [TGT_N-1:0]  tgt_d;
  logic [ADDR_W-1:0] ram_d;

  assign mode = '{alt_zp: alt_zp, aux_rd: aux_rd, aux_wr: aux_wr,
                  store80: store80, page2: page2, text_mode: text_mode,
                  slot_rom_int: slot_rom_int, slot3_card: slot3_card,
                  lc_ram_rd: lc_ram_rd, lc_wr_inh: lc_wr_inh};

  bank_seg_classify #(.ADDR_W(ADDR_W)) u_cls (.addr(addr), .seg(seg));

  bank_target_route u_route (.seg(seg), .wr(wr), .mode(mode), .tgt(tgt_d));

  bank_addr_fold #(.ADDR_W(ADDR_W), .BANK_LOG2(BANK_LOG2)) u_fold (
    .addr(addr), .seg(seg), .bank2(lc_bank2), .ram_addr(ram_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_sel  <= TGT_N'(1) << TGT_NONE;
      ram_addr <= '0;
    end else begin
      tgt_sel  <= tgt_d;
      ram_addr <= ram_d;
    end
  end
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr,
  input logic              alt_zp,
  input logic              lc_wr_inh,
  input logic              lc_bank2,
  input logic [4:0]        tgt_sel,
  input logic [ADDR_W-1:0] ram_addr
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(tgt_sel) == 1);

  p_zp_alt_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr) < 16'h0200 && $past(alt_zp)) |-> tgt_sel == 5'b00010);

  p_io_page_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr[15:8]) == 8'hC0) |-> tgt_sel == 5'b01000);

  p_lc_wr_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr[15:12]) >= 4'hD && $past(wr) && $past(lc_wr_inh))
      |-> tgt_sel == 5'b10000);

  p_bank_fold_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr[15:12]) == 4'hD && !$past(lc_bank2))
      |-> ram_addr == {4'hC, $past(addr[11:0])});
endmodule

bind bank_decoder bank_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr(wr), .alt_zp(alt_zp),
  .lc_wr_inh(lc_wr_inh), .lc_bank2(lc_bank2),
  .tgt_sel(tgt_sel), .ram_addr(ram_addr)
);

// File: tb/bank_decoder_tb.sv
module bank_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] addr = '0;
  logic wr = 1'b0;
  logic [10:0] fl = '0;
  logic [4:0]  tgt_sel;
  logic [15:0] ram_addr;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // fl bits: 0 alt_zp,1 aux_rd,2 aux_wr,3 store80,4 page2,5 text_mode,
  // 6 slot_rom_int,7 slot3_card,8 lc_ram_rd,9 lc_wr_inh,10 lc_bank2
  bank_decoder u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr(wr),
    .alt_zp(fl[0]), .aux_rd(fl[1]), .aux_wr(fl[2]), .store80(fl[3]),
    .page2(fl[4]), .text_mode(fl[5]), .slot_rom_int(fl[6]),
    .slot3_card(fl[7]), .lc_ram_rd(fl[8]), .lc_wr_inh(fl[9]),
    .lc_bank2(fl[10]), .tgt_sel(tgt_sel), .ram_addr(ram_addr)
  );

  localparam logic [4:0] MAIN = 5'b00001, AUX = 5'b00010, ROM = 5'b00100,
                         IO = 5'b01000, NONE = 5'b10000;

  function automatic logic [4:0] ram_pick(input logic a);
    return a ? AUX : MAIN;
  endfunction

  function automatic logic [4:0] exp_tgt(input logic [15:0] a, input logic w,
                                         input logic [10:0] f);
    logic dir;
    dir = w ? f[2] : f[1];
    if (a <= 16'h01FF) return ram_pick(f[0]);                         // R2
    if (a >= 16'h0400 && a <= 16'h07FF)                               // R4
      return f[3] ? ram_pick(f[4]) : ram_pick(dir);
    if (a >= 16'h1000 && a <= 16'h1FFF)                               // R5
      return f[3] ? ram_pick(f[4] & ~f[5]) : ram_pick(dir);
    if (a <= 16'hBFFF) return ram_pick(dir);                          // R3
    if (a <= 16'hC0FF) return IO;                                     // R6
    if (a >= 16'hC300 && a <= 16'hC3FF)                               // R8
      return (f[6] || !f[7]) ? ROM : NONE;
    if (a <= 16'hCFFF) return f[6] ? ROM : NONE;                      // R7
    if (w) return f[9] ? NONE : ram_pick(f[0]);                       // R10
    return f[8] ? ram_pick(f[0]) : ROM;                               // R9
  endfunction

  function automatic logic [15:0] exp_ram(input logic [15:0] a, input logic [10:0] f);
    if (a >= 16'hD000 && a <= 16'hDFFF && !f[10]) return a - 16'h1000; // R11
    return a;
  endfunction

  function automatic string req_of(input logic [15:0] a, input logic w);
    if (a <= 16'h01FF) return "R2";
    if (a >= 16'h0400 && a <= 16'h07FF) return "R4";
    if (a >= 16'h1000 && a <= 16'h1FFF) return "R5";
    if (a <= 16'hBFFF) return "R3";
    if (a <= 16'hC0FF) return "R6";
    if (a >= 16'hC300 && a <= 16'hC3FF) return "R8";
    if (a <= 16'hCFFF) return "R7";
    return w ? "R10" : "R9";
  endfunction

  task automatic access(input logic [15:0] a, input logic w, input logic [10:0] f);
    logic [4:0]  et;
    logic [15:0] ea;
    @(negedge clk);
    addr = a; wr = w; fl = f;
    et = exp_tgt(a, w, f);
    ea = exp_ram(a, f);
    @(posedge clk); #1;
    n_chk++;
    if (tgt_sel !== et) begin
      n_fail++;
      $display("FAIL %s addr=%h wr=%0b flags=%b tgt_sel actual=%b expected=%b",
               req_of(a, w), a, w, f, tgt_sel, et);
    end
    n_chk++;
    if (ram_addr !== ea) begin
      n_fail++;
      $display("FAIL R11 addr=%h flags=%b ram_addr actual=%h expected=%h",
               a, f, ram_addr, ea);
    end
  endtask

  localparam int NB = 24;
  logic [15:0] edges [NB] = '{16'h0000, 16'h01FF, 16'h0200, 16'h03FF, 16'h0400,
    16'h07FF, 16'h0800, 16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000, 16'hBFFF,
    16'hC000, 16'hC0FF, 16'hC100, 16'hC2FF, 16'hC300, 16'hC3FF, 16'hC400,
    16'hCFFF, 16'hD000, 16'hDFFF, 16'hE000, 16'hFFFF};

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    n_chk++;
    if (tgt_sel !== NONE || ram_addr !== 16'h0000) begin
      n_fail++;
      $display("FAIL R1 reset tgt_sel actual=%b expected=%b ram_addr actual=%h expected=0000",
               tgt_sel, NONE, ram_addr);
    end
    @(negedge clk); rst = 1'b0;

    // Directed: every boundary, both directions, all-clear, all-set, each flag alone
    for (int e = 0; e < NB; e++) begin
      for (int w = 0; w < 2; w++) begin
        access(edges[e], w[0], 11'h000);
        access(edges[e], w[0], 11'h7FF);
        for (int b = 0; b < 11; b++) begin
          access(edges[e], w[0], 11'(1) << b);
          access(edges[e], w[0], 11'h7FF ^ (11'(1) << b));
        end
      end
    end
    // Display override against opposite aux flag (R4, R5)
    access(16'h0400, 1'b0, 11'b000_0001_1000); // store80+page2, aux_rd=0 -> aux
    access(16'h0400, 1'b0, 11'b000_0000_1010); // store80, aux_rd=1 -> main
    access(16'h1000, 1'b1, 11'b000_0011_1000); // text blocks page2 -> main
    access(16'h1FFF, 1'b1, 11'b000_0001_1000); // -> aux
    // R11 fold edges
    access(16'hDFFF, 1'b0, 11'b001_0000_0000);
    access(16'hE000, 1'b0, 11'b001_0000_0000);

    // R1 reset re-entry mid-run
    @(negedge clk); addr = 16'h2000; fl = 11'h7FF; rst = 1'b1;
    @(posedge clk); #1;
    n_chk++;
    if (tgt_sel !== NONE || ram_addr !== 16'h0000) begin
      n_fail++;
      $display("FAIL R1 reset re-entry tgt_sel actual=%b expected=%b ram_addr actual=%h expected=0000",
               tgt_sel, NONE, ram_addr);
    end
    @(negedge clk); rst = 1'b0;

    // Random
    for (int i = 0; i < 3000; i++)
      access(16'($urandom), 1'($urandom), 11'($urandom));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule